// File: doc/BRIEF.md
# Interrupt Request and Poll Node

This block is the device-side end of a shared interrupt scheme. An external condition is turned into a request on one bit of a shared request-in bus. The device then takes part in a daisy-chained poll. The bit it drives is the one picked by a level value. A prepare command loads that level and an enable (mask) bit, and the command counts only while the data strobe is high. A pending request stays on the bus until a poll is captured, the mask is cleared, or a reset of any kind arrives.

The channel starts a poll by presenting a poll identifier. The identifier says whether the poll is for an interrupt and which level it concerns. One clock after a matching identifier is seen, the node freezes its capture-or-pass decision. From then on, changes in the request state cannot alter that decision. On the leading edge of the incoming poll tag, the node does one of two things. If the frozen decision says a request is pending, it captures the poll. Otherwise it passes the tag on to the next device. That choice is held until a poll-return or burst-return indication ends the poll.

All outputs are registered, and every reset source acts synchronously.

Top module: `irqpoll_node`

## Requirements
- R1: When a condition is recorded while enabled, exactly one bit of `req_in` goes high one clock later, and that bit is bit number `level` (bit index equals the stored level value). `req_in` never has more than one bit set.
- R2: While the stored mask bit is 0, `ext_irq` is ignored and `req_in` stays all zero.
- R3: Once a request bit is high, it keeps its value until one of these happens: a captured poll, a strobed prepare command, or a reset event.
- R4: `rst_por`, `rst_sys` and `halt_mchk` each clear the mask, the level, the request and the poll state at the next clock. So does `dev_reset` together with `data_strobe`. A `dev_reset` without `data_strobe` has no effect.
- R5: A prepare command (`prep_valid` with `data_strobe`) loads `prep_mask` and `prep_level` at the next clock. If the new mask is 0, a pending request is dropped. If the new mask is 1, a pending request moves to the new level. Either change shows on `req_in` in the clock after the strobed command, while the strobe may still be high.
- R6: The poll identifier matches when `poll_id_valid` and `poll_id_irq` are 1 and `poll_id_level` equals the stored level. One clock after a match, the capture decision is frozen. The frozen decision is true if a request was pending, or a condition was arriving with the mask at 1, in the matching cycle. Later request changes do not alter it while the match persists.
- R7: On a rising edge of `poll_in`, the node captures if the identifier matches and the decision (frozen, or current if not yet frozen) is true. Otherwise it propagates. A capture clears the pending request.
- R8: `poll_captured` or `poll_out` stays high until `poll_return` or `burst_return` is seen, even if `poll_in` falls earlier. It drops one clock after the return.
- R9: The result of a poll edge appears on `poll_captured` or `poll_out` one clock after the edge is sampled. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_sys | input | 1 | System reset, synchronous, active high |
| halt_mchk | input | 1 | Halt or machine-check clear |
| dev_reset | input | 1 | Device-directed reset, acts with data_strobe |
| data_strobe | input | 1 | Command strobe qualifying prepare and device reset |
| prep_valid | input | 1 | Prepare command present |
| prep_mask | input | 1 | Mask value carried by prepare |
| prep_level | input | LVL_W | Level carried by prepare |
| ext_irq | input | 1 | External interrupting condition |
| poll_id_valid | input | 1 | Poll identifier active |
| poll_id_irq | input | 1 | Identifier type: 1 interrupt, 0 storage access |
| poll_id_level | input | LVL_W | Level named by the identifier |
| poll_in | input | 1 | Incoming poll tag from upstream |
| poll_return | input | 1 | Poll-return indication ending the poll |
| burst_return | input | 1 | Burst-return indication ending the poll |
| req_in | output | NUM_LEVELS | One-hot request-in bus contribution |
| poll_captured | output | 1 | Poll captured by this node |
| poll_out | output | 1 | Poll tag propagated downstream |

## Verification
A new condition can arrive in the same cycle in which the identifier match freezes the decision. The test raises `ext_irq` in the very cycle the identifier first matches, with nothing pending yet, and then expects a capture on the following poll edge. The converse case is also tested. A condition that arrives after the freeze must leave the request on the bus, but the poll must still be passed on. In a further case, a strobed prepare that clears the mask after the freeze must not stop the capture. The random phase mixes prepare commands, conditions and reset sources in the same cycles. Each clock, `req_in` is compared with a bench model built from R1 to R5.

// File: rtl/irqpoll_pkg.sv
package irqpoll_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CAPT = 2'd1,
    PS_PASS = 2'd2
  } poll_st_e;

endpackage

// File: rtl/irqpoll_req_ctrl.sv
module irqpoll_req_ctrl #(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  prep_do,
  input  logic                  prep_mask,
  input  logic [LVL_W-1:0]      prep_level,
  input  logic                  ext_irq,
  input  logic                  capture,
  output logic [NUM_LEVELS-1:0] req_q,
  output logic                  mask_q,
  output logic [LVL_W-1:0]      lvl_q,
  output logic                  pend_q
);

  logic                  mask_n;
  logic                  pend_n;
  logic [LVL_W-1:0]      lvl_n;
  logic [NUM_LEVELS-1:0] req_n;

  always_comb begin
    mask_n = prep_do ? prep_mask  : mask_q;
    lvl_n  = prep_do ? prep_level : lvl_q;
    if (capture) pend_n = 1'b0;
    else         pend_n = mask_n & (pend_q | ext_irq);
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_dec
    assign req_n[g] = pend_n && (lvl_n == LVL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      mask_q <= 1'b0;
      lvl_q  <= '0;
      pend_q <= 1'b0;
      req_q  <= '0;
    end else begin
      mask_q <= mask_n;
      lvl_q  <= lvl_n;
      pend_q <= pend_n;
      req_q  <= req_n;
    end
  end

  // R1: never more than one request bit
  p_onehot_r1: assert property (@(posedge clk) disable iff (clr)
    $onehot0(req_q));

  // R2: masked device shows no request
  p_mask_gate_r2: assert property (@(posedge clk) disable iff (clr)
    !mask_q |-> (req_q == '0));

  // R3: active request persists without a clearing event
  p_hold_r3: assert property (@(posedge clk) disable iff (clr)
    (|req_q && !prep_do && !capture) |=> (req_q == $past(req_q)));

  // R5: enabled prepare moves a pending request
  p_move_r5: assert property (@(posedge clk) disable iff (clr)
    (|req_q && prep_do && prep_mask && !capture)
      |=> (req_q == (NUM_LEVELS'(1) << $past(prep_level))));

endmodule

// File: rtl/irqpoll_decider.sv
module irqpoll_decider #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             id_valid,
  input  logic             id_irq,
  input  logic [LVL_W-1:0] id_level,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic             pend_q,
  input  logic             mask_q,
  input  logic             ext_irq,
  input  logic             done,
  output logic             id_match,
  output logic             cap_now
);

  logic locked;
  logic dec_cap;
  logic cand;

  assign id_match = id_valid && id_irq && (id_level == lvl_q);
  assign cand     = pend_q | (ext_irq & mask_q);
  assign cap_now  = locked ? dec_cap : cand;

  always_ff @(posedge clk) begin
    if (clr) begin
      locked  <= 1'b0;
      dec_cap <= 1'b0;
    end else if (!id_match || done) begin
      locked  <= 1'b0;
    end else if (!locked) begin
      locked  <= 1'b1;
      dec_cap <= cand;
    end
  end

  // R6: frozen decision stays fixed while the match persists
  p_frozen_r6: assert property (@(posedge clk) disable iff (clr)
    (locked && id_match && !done) |=> (locked && $stable(dec_cap)));

endmodule

// File: rtl/irqpoll_chain_fsm.sv
module irqpoll_chain_fsm
  import irqpoll_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic poll_in,
  input  logic poll_ret,
  input  logic burst_ret,
  input  logic id_match,
  input  logic cap_now,
  output logic capture,
  output logic poll_out,
  output logic poll_captured
);

  poll_st_e state;
  logic     poll_q;
  logic     rise;
  logic     ret;

  assign rise    = poll_in & ~poll_q;
  assign ret     = poll_ret | burst_ret;
  assign capture = (state == PS_IDLE) && rise && id_match && cap_now;

  always_ff @(posedge clk) begin
    poll_q <= poll_in;
    if (clr) begin
      state <= PS_IDLE;
    end else begin
      case (state)
        PS_IDLE: if (rise) state <= capture ? PS_CAPT : PS_PASS;
        PS_CAPT,
        PS_PASS: if (ret) state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign poll_captured = (state == PS_CAPT);
  assign poll_out      = (state == PS_PASS);

  // R8: held until a return indication
  p_hold_r8: assert property (@(posedge clk) disable iff (clr)
    (state != PS_IDLE && !ret) |=> $stable(state));

  // R9: exclusive outcomes
  p_excl_r9: assert property (@(posedge clk) disable iff (clr)
    !(poll_out && poll_captured));

  // R9: an edge in idle always yields an outcome
  p_edge_r9: assert property (@(posedge clk) disable iff (clr)
    (state == PS_IDLE && rise) |=> (poll_out || poll_captured));

endmodule

// File: rtl/irqpoll_node.sv
module irqpoll_node #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_por,
  input  logic                  rst_sys,
  input  logic                  halt_mchk,
  input  logic                  dev_reset,
  input  logic                  data_strobe,
  input  logic                  prep_valid,
  input  logic                  prep_mask,
  input  logic [LVL_W-1:0]      prep_level,
  input  logic                  ext_irq,
  input  logic                  poll_id_valid,
  input  logic                  poll_id_irq,
  input  logic [LVL_W-1:0]      poll_id_level,
  input  logic                  poll_in,
  input  logic                  poll_return,
  input  logic                  burst_return,
  output logic [NUM_LEVELS-1:0] req_in,
  output logic                  poll_captured,
  output logic                  poll_out
);

  logic             clr;
  logic             prep_do;
  logic             capture;
  logic             mask_q;
  logic             pend_q;
  logic [LVL_W-1:0] lvl_q;
  logic             id_match;
  logic             cap_now;

  assign clr     = rst_por | rst_sys | halt_mchk | (dev_reset & data_strobe);
  assign prep_do = prep_valid & data_strobe;

  irqpoll_req_ctrl #(
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W)
  ) u_req (
    .clk       (clk),
    .clr       (clr),
    .prep_do   (prep_do),
    .prep_mask (prep_mask),
    .prep_level(prep_level),
    .ext_irq   (ext_irq),
    .capture   (capture),
    .req_q     (req_in),
    .mask_q    (mask_q),
    .lvl_q     (lvl_q),
    .pend_q    (pend_q)
  );

  irqpoll_decider #(
    .LVL_W(LVL_W)
  ) u_dec (
    .clk     (clk),
    .clr     (clr),
    .id_valid(poll_id_valid),
    .id_irq  (poll_id_irq),
    .id_level(poll_id_level),
    .lvl_q   (lvl_q),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .ext_irq (ext_irq),
    .done    (poll_return | burst_return),
    .id_match(id_match),
    .cap_now (cap_now)
  );

  irqpoll_chain_fsm u_fsm (
    .clk          (clk),
    .clr          (clr),
    .poll_in      (poll_in),
    .poll_ret     (poll_return),
    .burst_ret    (burst_return),
    .id_match     (id_match),
    .cap_now      (cap_now),
    .capture      (capture),
    .poll_out     (poll_out),
    .poll_captured(poll_captured)
  );

  // R4: every reset source empties the bus and the poll state
  p_clear_r4: assert property (@(posedge clk) disable iff (rst_por)
    clr |=> (req_in == '0 && !poll_out && !poll_captured));

  // R7: a capture removes this node's request
  p_capclr_r7: assert property (@(posedge clk) disable iff (clr)
    capture |=> (req_in == '0));

endmodule

// File: tb/irqpoll_node_tb_top.sv
`timescale 1ns/1ps
module irqpoll_node_tb_top;

  localparam int NL = 4;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_por, rst_sys, halt_mchk, dev_reset, data_strobe;
  logic prep_valid, prep_mask, ext_irq;
  logic [LW-1:0] prep_level, poll_id_level;
  logic poll_id_valid, poll_id_irq, poll_in, poll_return, burst_return;
  logic [NL-1:0] req_in;
  logic poll_captured, poll_out;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model of the request side (R1..R5)
  logic          m_mask;
  logic [LW-1:0] m_lvl;
  logic          m_pend;

  always #10 clk = ~clk;

  irqpoll_node #(.NUM_LEVELS(NL)) dut_i (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .halt_mchk(halt_mchk),
    .dev_reset(dev_reset), .data_strobe(data_strobe), .prep_valid(prep_valid),
    .prep_mask(prep_mask), .prep_level(prep_level), .ext_irq(ext_irq),
    .poll_id_valid(poll_id_valid), .poll_id_irq(poll_id_irq),
    .poll_id_level(poll_id_level), .poll_in(poll_in), .poll_return(poll_return),
    .burst_return(burst_return), .req_in(req_in), .poll_captured(poll_captured),
    .poll_out(poll_out)
  );

  function automatic logic [NL-1:0] exp_req(input logic pend, input logic [LW-1:0] lvl);
    return pend ? (NL'(1) << lvl) : '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    rst_por = 0; rst_sys = 0; halt_mchk = 0; dev_reset = 0; data_strobe = 0;
    prep_valid = 0; prep_mask = 0; prep_level = '0; ext_irq = 0;
    poll_id_valid = 0; poll_id_irq = 0; poll_id_level = '0;
    poll_in = 0; poll_return = 0; burst_return = 0;
  endtask

  // one clock: model update at the edge, then settle to the falling edge
  task automatic step();
    logic any_rst, pd, mn;
    @(posedge clk);
    any_rst = rst_por | rst_sys | halt_mchk | (dev_reset & data_strobe);
    pd = prep_valid & data_strobe;
    if (any_rst) begin
      m_mask = 0; m_lvl = '0; m_pend = 0;
    end else begin
      mn = pd ? prep_mask : m_mask;
      if (pd) m_lvl = prep_level;
      m_pend = mn & (m_pend | ext_irq);
      m_mask = mn;
    end
    @(negedge clk);
  endtask

  task automatic hard_reset();
    idle_inputs(); rst_sys = 1; step(); rst_sys = 0;
  endtask

  task automatic prepare(input logic mk, input logic [LW-1:0] lv);
    prep_valid = 1; data_strobe = 1; prep_mask = mk; prep_level = lv;
    step();
    prep_valid = 0; data_strobe = 0;
  endtask

  task automatic set_id(input logic [LW-1:0] lv);
    poll_id_valid = 1; poll_id_irq = 1; poll_id_level = lv;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_mask = 0; m_lvl = '0; m_pend = 0;
    idle_inputs();
    rst_por = 1;
    step(); step();
    rst_por = 0;
    // reset state
    chk("R4 reset req_in", 32'(req_in), 0);
    chk("R4 reset poll_out", 32'(poll_out), 0);
    chk("R4 reset poll_captured", 32'(poll_captured), 0);

    // R2: masked device ignores a condition
    ext_irq = 1; step(); ext_irq = 0;
    chk("R2 masked condition", 32'(req_in), 0);

    // R1: enabled at level 2
    prepare(1, 2);
    ext_irq = 1; step(); ext_irq = 0;
    chk("R1 onehot level 2", 32'(req_in), 32'h4);
    step(); step();
    chk("R3 request persists", 32'(req_in), 32'h4);

    // R5: move while strobe still high (two-cycle strobe)
    prep_valid = 1; data_strobe = 1; prep_mask = 1; prep_level = 3;
    step();
    chk("R5 moved to level 3", 32'(req_in), 32'h8);
    prep_valid = 0; step(); data_strobe = 0;

    // R4: device reset without strobe is ignored
    dev_reset = 1; step(); dev_reset = 0;
    chk("R4 dev_reset unstrobed ignored", 32'(req_in), 32'h8);
    // R4: strobed device reset clears, mask cleared too
    dev_reset = 1; data_strobe = 1; step(); dev_reset = 0; data_strobe = 0;
    chk("R4 dev_reset clears", 32'(req_in), 0);
    ext_irq = 1; step(); ext_irq = 0;
    chk("R4 mask cleared by reset", 32'(req_in), 0);

    // R4: halt clears
    prepare(1, 1); ext_irq = 1; step(); ext_irq = 0;
    chk("R1 onehot level 1", 32'(req_in), 32'h2);
    halt_mchk = 1; step(); halt_mchk = 0;
    chk("R4 halt clears", 32'(req_in), 0);

    // R5: prepare with mask 0 drops the request
    prepare(1, 0); ext_irq = 1; step(); ext_irq = 0;
    chk("R1 onehot level 0", 32'(req_in), 32'h1);
    prepare(0, 0);
    chk("R5 mask off drops", 32'(req_in), 0);

    // R7: capture with pending request at identified level
    hard_reset();
    prepare(1, 2); ext_irq = 1; step(); ext_irq = 0;
    set_id(2); step();
    poll_in = 1; step();
    chk("R7 captured", 32'(poll_captured), 1);
    chk("R9 no propagate on capture", 32'(poll_out), 0);
    chk("R7 capture clears request", 32'(req_in), 0);
    poll_in = 0; step(); step();
    chk("R8 hold after poll falls", 32'(poll_captured), 1);
    poll_return = 1; step(); poll_return = 0;
    chk("R8 released by poll_return", 32'(poll_captured), 0);
    poll_id_valid = 0; step();

    // R7: no request -> propagate; burst_return ends
    hard_reset(); prepare(1, 1);
    set_id(1); step();
    poll_in = 1; step();
    chk("R7 propagate without request", 32'(poll_out), 1);
    chk("R9 no capture on propagate", 32'(poll_captured), 0);
    poll_in = 0; step();
    chk("R8 propagate held", 32'(poll_out), 1);
    burst_return = 1; step(); burst_return = 0;
    chk("R8 released by burst_return", 32'(poll_out), 0);
    poll_id_valid = 0; step();

    // R6: condition after freeze does not capture, stays on bus
    hard_reset(); prepare(1, 1);
    set_id(1); step();
    ext_irq = 1; step(); ext_irq = 0;
    chk("R6 late request on bus", 32'(req_in), 32'h2);
    poll_in = 1; step();
    chk("R6 frozen pass", 32'(poll_out), 1);
    chk("R6 late request kept", 32'(req_in), 32'h2);
    poll_in = 0; poll_return = 1; step(); poll_return = 0;
    poll_id_valid = 0; step();

    // R6: condition in the match cycle is included in the decision
    hard_reset(); prepare(1, 2);
    set_id(2); ext_irq = 1; step(); ext_irq = 0;
    poll_in = 1; step();
    chk("R6 same-cycle condition captured", 32'(poll_captured), 1);
    poll_in = 0; poll_return = 1; step(); poll_return = 0;
    poll_id_valid = 0; step();

    // R6: mask cleared after freeze still captures
    hard_reset(); prepare(1, 3); ext_irq = 1; step(); ext_irq = 0;
    set_id(3); step();
    prepare(0, 3);
    chk("R5 request dropped", 32'(req_in), 0);
    poll_in = 1; step();
    chk("R6 frozen capture after clear", 32'(poll_captured), 1);
    poll_in = 0; burst_return = 1; step(); burst_return = 0;
    poll_id_valid = 0; step();

    // R7: identifier names another level -> propagate, request kept
    hard_reset(); prepare(1, 1); ext_irq = 1; step(); ext_irq = 0;
    set_id(3); step();
    poll_in = 1; step();
    chk("R7 mismatched level propagates", 32'(poll_out), 1);
    chk("R7 mismatched level keeps request", 32'(req_in), 32'h2);
    poll_in = 0; poll_return = 1; step(); poll_return = 0;
    poll_id_valid = 0;
    // R4: system reset clears a held request
    rst_sys = 1; step(); rst_sys = 0;
    chk("R4 system reset clears", 32'(req_in), 0);

    // random phase on the request side (R1..R5)
    hard_reset();
    void'($urandom(32'd4242));
    for (int i = 0; i < 400; i++) begin
      prep_valid  = ($urandom % 6) == 0;
      prep_mask   = ($urandom % 4) != 0;
      prep_level  = LW'($urandom);
      data_strobe = $urandom % 2;
      ext_irq     = ($urandom % 3) == 0;
      dev_reset   = ($urandom % 20) == 0;
      halt_mchk   = ($urandom % 60) == 0;
      rst_sys     = ($urandom % 80) == 0;
      rst_por     = ($urandom % 120) == 0;
      step();
      chk("R1 R3 R5 random req_in", 32'(req_in), 32'(exp_req(m_pend, m_lvl)));
    end
    idle_inputs(); step();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule